// File: doc/BRIEF.md
# Program Sequencer with Three-Level Return Stack

This block produces the instruction fetch address for a small 4-bit processor. It holds a 12-bit program counter and a fixed three-entry hardware return stack. The stack has no pointer register: entries shift down on a call and up on a return. On each instruction step, the block decodes the first instruction word. It then either advances past the instruction or loads a control-transfer target. The supported transfers are a long jump, a subroutine call, a return, a conditional short jump and an indirect short jump through a register pair.

The surrounding core presents both instruction words together with `step`. It also presents the accumulator-zero flag, the carry flag, the external test input and the byte read from the selected register pair. From the first word alone, the block tells the fetch logic whether a second word belongs to the instruction. A return also hands a 4-bit immediate to the accumulator. This is a one-cycle strobe that appears in the cycle after the step.

Top module: `prog_seq`

## Requirements
- R1: A synchronous active-low reset sets `pc` to 0x000, clears `acc_ld`, and sets every stack slot to 0x000. A return executed straight after reset therefore goes to 0x000.
- R2: The counter moves only on a clock edge with `step` high. A one-word instruction advances it by one and a two-word instruction by two, modulo 4096. Two-word instructions are FIM and ISZ (high nibbles 2-even and 7); their own operations are handled outside this block.
- R3: `fetch_word2` is high exactly when `word1[7:4]` is 1, 4, 5 or 7, or is 2 with `word1[0]`=0. It depends on `word1` alone.
- R4: A long jump (`word1[7:4]`=4) loads `pc` with {`word1[3:0]`, `word2`}.
- R5: A call (`word1[7:4]`=5) loads `pc` with {`word1[3:0]`, `word2`} and saves the call address plus two as the newest stack entry.
- R6: A return (`word1[7:4]`=C) loads `pc` with the newest stack entry. In the next cycle only, `acc_ld` is high and `acc_val` equals `word1[3:0]`.
- R7: Three nested calls return in last-in-first-out order.
- R8: A fourth nested call discards the oldest saved address. A pop leaves the deepest slot unchanged, so a return with nothing left returns the deepest slot's value again.
- R9: The conditional jump (`word1[7:4]`=1) ORs three selected terms before any inversion. Bit 2 selects `acc_zero`=1, bit 1 selects `carry`=1, and bit 0 selects `test_in`=0. A mask of 0000 with bit 3 clear never jumps. When the jump is not taken, the counter advances by two.
- R10: Bit 3 of the conditional nibble inverts the jump decision.
- R11: A taken conditional jump loads {upper nibble of (`pc`+2), `word2`}, so an instruction whose second word ends a 256-word page jumps into the next page.
- R12: An indirect jump (`word1[7:4]`=3 with `word1[0]`=1) loads {upper nibble of (`pc`+1), `pair_data`}. With `word1[0]`=0 the counter advances by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step | input | 1 | Execute the presented instruction at this edge |
| word1 | input | 8 | First instruction word |
| word2 | input | 8 | Second instruction word |
| acc_zero | input | 1 | Accumulator equals zero |
| carry | input | 1 | Carry flag |
| test_in | input | 1 | External test input |
| pair_data | input | 8 | Contents of the addressed register pair |
| pc | output | 12 | Next fetch address |
| fetch_word2 | output | 1 | Instruction needs a second word |
| acc_ld | output | 1 | Accumulator load strobe from a return |
| acc_val | output | 4 | Value to load into the accumulator |

## Verification
The bench places conditional and indirect jumps at the last words of a page. A design that took the upper address bits from the instruction's own address would then stay in the old page. It nests four calls and then returns more times than it called. A stack that wrapped around, or that zero-filled its deepest slot on a pop, would return the wrong addresses. Each condition term is tested separately and together with the invert bit, which exposes a design that inverts before the OR or that reads the test input's polarity backwards. Sequential advance is checked across the 4095-to-0 wrap and for two-word opcodes that do not branch here.

// File: rtl/prog_seq_pkg.sv
// Package: shared widths and the control-transfer class decoded from word 1.
// Assumes an 8-bit instruction word with the opcode in the high nibble.
package prog_seq_pkg;
    localparam int WORD_W = 8;
    localparam int NIB_W  = 4;

    typedef enum logic [2:0] {
        XFER_SEQ,   // plain advance
        XFER_LONG,  // long jump
        XFER_CALL,  // subroutine call
        XFER_RET,   // return with immediate
        XFER_COND,  // conditional short jump
        XFER_IND    // indirect short jump
    } xfer_e;

    localparam logic [3:0] OPC_COND = 4'h1;
    localparam logic [3:0] OPC_PAIR = 4'h2;
    localparam logic [3:0] OPC_IND  = 4'h3;
    localparam logic [3:0] OPC_LONG = 4'h4;
    localparam logic [3:0] OPC_CALL = 4'h5;
    localparam logic [3:0] OPC_ISZ  = 4'h7;
    localparam logic [3:0] OPC_RET  = 4'hC;
endpackage

// File: rtl/prog_seq_decode.sv
// Module: prog_seq_decode
// Classifies the first instruction word into a transfer kind, flags
// two-word instructions, and evaluates the conditional-jump decision.
// Assumes: purely combinational; flags are valid in the step cycle.
module prog_seq_decode
    import prog_seq_pkg::*;
(
    input  logic [WORD_W-1:0] word1,
    input  logic              acc_zero,
    input  logic              carry,
    input  logic              test_in,
    output xfer_e             kind,
    output logic              two_word,
    output logic              cond_take
);
    logic [NIB_W-1:0] opc;
    logic [NIB_W-1:0] cnd;
    logic             any_term;

    assign opc = word1[WORD_W-1 -: NIB_W];
    assign cnd = word1[NIB_W-1:0];

    // Map opcode nibble to transfer class.
    always_comb begin
        unique case (opc)
            OPC_LONG: kind = XFER_LONG;
            OPC_CALL: kind = XFER_CALL;
            OPC_RET:  kind = XFER_RET;
            OPC_COND: kind = XFER_COND;
            OPC_IND:  kind = word1[0] ? XFER_IND : XFER_SEQ;
            default:  kind = XFER_SEQ;
        endcase
    end

    // Instruction length from opcode nibble.
    always_comb begin
        unique case (opc)
            OPC_COND, OPC_LONG, OPC_CALL, OPC_ISZ: two_word = 1'b1;
            OPC_PAIR: two_word = ~word1[0];
            default:  two_word = 1'b0;
        endcase
    end

    // OR the selected terms, then apply the invert bit.
    always_comb begin
        any_term  = (cnd[2] & acc_zero) | (cnd[1] & carry) | (cnd[0] & ~test_in);
        cond_take = any_term ^ cnd[3];
    end

    // R3: a transfer other than an indirect jump is never a one-word
    // instruction, except the return.
    always_comb begin
        if (kind == XFER_LONG || kind == XFER_CALL || kind == XFER_COND)
            a_r3_branch_len: assert (two_word);
        if (kind == XFER_RET || kind == XFER_IND)
            a_r3_short_len: assert (!two_word);
    end
endmodule

// File: rtl/prog_seq_stack.sv
// Module: prog_seq_stack
// Fixed-depth shift-register return stack without a pointer. A push
// shifts every slot one deeper and drops the deepest. A pop shifts
// every slot one shallower while the deepest slot keeps its value.
// Assumes: DEPTH >= 2; push and pop never in the same cycle.
module prog_seq_stack #(
    parameter int DEPTH = 3,
    parameter int W     = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top
);
    localparam int LAST = DEPTH - 1;

    logic [W-1:0] slot [DEPTH];

    assign top = slot[0];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (i == 0) begin : g_top
            // Newest slot: load on push, take next deeper on pop.
            always_ff @(posedge clk) begin
                if (!rst_n)    slot[i] <= '0;
                else if (push) slot[i] <= push_data;
                else if (pop)  slot[i] <= slot[i+1];
            end
        end else if (i == LAST) begin : g_bottom
            // Deepest slot: shift in on push, hold on pop.
            always_ff @(posedge clk) begin
                if (!rst_n)    slot[i] <= '0;
                else if (push) slot[i] <= slot[i-1];
            end
        end else begin : g_mid
            // Middle slot: shift deeper on push, shallower on pop.
            always_ff @(posedge clk) begin
                if (!rst_n)    slot[i] <= '0;
                else if (push) slot[i] <= slot[i-1];
                else if (pop)  slot[i] <= slot[i+1];
            end
        end
    end

    // R7: a push moves the former newest entry one slot deeper.
    a_r7_push_shift: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> slot[1] == $past(slot[0]));

    // R7: a pop exposes the former second entry.
    a_r7_pop_shift: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> top == $past(slot[1]));

    // R8: the deepest slot survives a pop.
    a_r8_bottom_kept: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> slot[LAST] == $past(slot[LAST]));

    // R8: the deepest slot changes only through a push.
    a_r8_bottom_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !push |=> $stable(slot[LAST]));

    // R5: push and pop are mutually exclusive.
    always_comb begin
        if (rst_n) a_r5_no_push_pop: assert (!(push && pop));
    end
endmodule

// File: rtl/prog_seq.sv
// Module: prog_seq (top)
// Program counter and next-address selection for a 4-bit processor with
// a three-level return stack. Executes one instruction per step pulse.
// Assumes: both instruction words are valid while step is high; the
// accumulator strobe is registered and appears in the cycle after step.
module prog_seq
    import prog_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [7:0]        word1,
    input  logic [7:0]        word2,
    input  logic              acc_zero,
    input  logic              carry,
    input  logic              test_in,
    input  logic [7:0]        pair_data,
    output logic [ADDR_W-1:0] pc,
    output logic              fetch_word2,
    output logic              acc_ld,
    output logic [3:0]        acc_val
);
    localparam int PAGE_W = ADDR_W - WORD_W;

    xfer_e             kind;
    logic              two_word;
    logic              cond_take;
    logic [ADDR_W-1:0] pc_inc1;
    logic [ADDR_W-1:0] pc_inc2;
    logic [ADDR_W-1:0] pc_next;
    logic [ADDR_W-1:0] ret_addr;
    logic              do_push;
    logic              do_pop;

    prog_seq_decode u_dec (
        .word1     (word1),
        .acc_zero  (acc_zero),
        .carry     (carry),
        .test_in   (test_in),
        .kind      (kind),
        .two_word  (two_word),
        .cond_take (cond_take)
    );

    prog_seq_stack #(.DEPTH(DEPTH), .W(ADDR_W)) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .pop       (do_pop),
        .push_data (pc_inc2),
        .top       (ret_addr)
    );

    assign fetch_word2 = two_word;
    assign pc_inc1     = pc + ADDR_W'(1);
    assign pc_inc2     = pc + ADDR_W'(2);
    assign do_push     = step && (kind == XFER_CALL);
    assign do_pop      = step && (kind == XFER_RET);

    // Select the address that follows the current instruction.
    always_comb begin
        unique case (kind)
            XFER_LONG, XFER_CALL: pc_next = {word1[PAGE_W-1:0], word2};
            XFER_RET:  pc_next = ret_addr;
            XFER_COND: pc_next = cond_take ? {pc_inc2[ADDR_W-1 -: PAGE_W], word2}
                                           : pc_inc2;
            XFER_IND:  pc_next = {pc_inc1[ADDR_W-1 -: PAGE_W], pair_data};
            default:   pc_next = two_word ? pc_inc2 : pc_inc1;
        endcase
    end

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)    pc <= '0;
        else if (step) pc <= pc_next;
    end

    // Accumulator load strobe and value from a return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_ld  <= 1'b0;
            acc_val <= '0;
        end else begin
            acc_ld  <= do_pop;
            if (do_pop) acc_val <= word1[NIB_W-1:0];
        end
    end

    // R2: the counter holds without a step.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(pc));

    // R4: a long jump lands on the full immediate address.
    a_r4_long: assert property (@(posedge clk) disable iff (!rst_n)
        (step && word1[7:4] == OPC_LONG) |=> pc == $past({word1[3:0], word2}));

    // R6: the load strobe only follows a return step.
    a_r6_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ld |-> $past(step && word1[7:4] == OPC_RET));

    // R6: a return lands on the value the stack exposed at the step.
    a_r6_ret_target: assert property (@(posedge clk) disable iff (!rst_n)
        do_pop |=> pc == $past(ret_addr));

    // R11: a taken short jump stays in the page of the following word.
    a_r11_page: assert property (@(posedge clk) disable iff (!rst_n)
        (step && kind == XFER_COND && cond_take)
            |=> pc[ADDR_W-1 -: PAGE_W] == $past(pc_inc2[ADDR_W-1 -: PAGE_W]));
endmodule

// File: tb/prog_seq_test.sv
module prog_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0;
    logic [7:0]  word1 = 8'h00, word2 = 8'h00, pair_data = 8'h00;
    logic        acc_zero = 1'b0, carry = 1'b0, test_in = 1'b1;
    logic [11:0] pc;
    logic        fetch_word2, acc_ld;
    logic [3:0]  acc_val;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    prog_seq uut (
        .clk(clk), .rst_n(rst_n), .step(step), .word1(word1), .word2(word2),
        .acc_zero(acc_zero), .carry(carry), .test_in(test_in),
        .pair_data(pair_data), .pc(pc), .fetch_word2(fetch_word2),
        .acc_ld(acc_ld), .acc_val(acc_val)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step  = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Present one instruction for one edge; return at the next falling edge.
    task automatic exec(input logic [7:0] w1, input logic [7:0] w2);
        word1 = w1;
        word2 = w2;
        step  = 1'b1;
        @(negedge clk);
        step  = 1'b0;
    endtask

    task automatic go_to(input logic [11:0] a);
        exec({4'h4, a[11:8]}, a[7:0]);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 pc", {4'h0, pc}, 16'h0000);
        check("R1 acc_ld", {15'h0, acc_ld}, 16'h0000);
        exec(8'hC3, 8'h00);
        check("R1 empty stack return", {4'h0, pc}, 16'h0000);
        check("R6 strobe", {15'h0, acc_ld}, 16'h0001);
        check("R6 value", {12'h0, acc_val}, 16'h0003);
        @(negedge clk);
        check("R6 strobe one cycle", {15'h0, acc_ld}, 16'h0000);
    endtask

    task automatic t_sequential();
        do_reset();
        exec(8'h00, 8'h00);
        check("R2 one-word", {4'h0, pc}, 16'h0001);
        exec(8'h20, 8'hAA);
        check("R2 two-word pair load", {4'h0, pc}, 16'h0003);
        exec(8'h7A, 8'h55);
        check("R2 two-word increment-skip", {4'h0, pc}, 16'h0005);
        exec(8'hE0, 8'h00);
        check("R2 one-word io", {4'h0, pc}, 16'h0006);
        @(negedge clk);
        @(negedge clk);
        check("R2 hold without step", {4'h0, pc}, 16'h0006);
        go_to(12'hFFF);
        exec(8'hF2, 8'h00);
        check("R2 wrap by one", {4'h0, pc}, 16'h0000);
        go_to(12'hFFF);
        exec(8'h22, 8'h00);
        check("R2 wrap by two", {4'h0, pc}, 16'h0001);
    endtask

    task automatic t_fetch2();
        logic [7:0] ops [10] = '{8'h10, 8'h20, 8'h21, 8'h31, 8'h4F, 8'h50, 8'h7E, 8'hC0, 8'hE0, 8'h00};
        logic       exp [10] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
        for (int i = 0; i < 10; i++) begin
            word1 = ops[i];
            #1;
            check("R3 fetch_word2", {15'h0, fetch_word2}, {15'h0, exp[i]});
        end
    endtask

    task automatic t_long();
        do_reset();
        exec(8'h4A, 8'h5C);
        check("R4 long jump", {4'h0, pc}, 16'h0A5C);
        exec(8'h40, 8'h00);
        check("R4 long jump to zero", {4'h0, pc}, 16'h0000);
    endtask

    task automatic t_nest();
        do_reset();
        go_to(12'h010);
        exec(8'h51, 8'h00);
        check("R5 call target", {4'h0, pc}, 16'h0100);
        exec(8'h52, 8'h00);
        exec(8'h53, 8'h00);
        check("R5 third call target", {4'h0, pc}, 16'h0300);
        exec(8'hC1, 8'h00);
        check("R7 return level 3", {4'h0, pc}, 16'h0202);
        check("R6 value level 3", {12'h0, acc_val}, 16'h0001);
        exec(8'hC2, 8'h00);
        check("R7 return level 2", {4'h0, pc}, 16'h0102);
        exec(8'hC9, 8'h00);
        check("R7 return level 1", {4'h0, pc}, 16'h0012);
        check("R6 value level 1", {12'h0, acc_val}, 16'h0009);
        exec(8'hC0, 8'h00);
        check("R8 over-pop repeats deepest", {4'h0, pc}, 16'h0012);
    endtask

    task automatic t_overflow();
        do_reset();
        go_to(12'h200);
        exec(8'h53, 8'h00);
        exec(8'h54, 8'h00);
        exec(8'h55, 8'h00);
        exec(8'h56, 8'h00);
        check("R8 fourth call target", {4'h0, pc}, 16'h0600);
        exec(8'hC0, 8'h00);
        check("R8 pop 1", {4'h0, pc}, 16'h0502);
        exec(8'hC0, 8'h00);
        check("R8 pop 2", {4'h0, pc}, 16'h0402);
        exec(8'hC0, 8'h00);
        check("R8 pop 3", {4'h0, pc}, 16'h0302);
        exec(8'hC0, 8'h00);
        check("R8 oldest dropped", {4'h0, pc}, 16'h0302);
    endtask

    // Run one conditional jump from 0x050; taken lands at 0x0E7, else 0x052.
    task automatic cond_case(input string req, input logic [3:0] c,
                             input logic az, input logic cy, input logic tst,
                             input logic take);
        go_to(12'h050);
        acc_zero = az; carry = cy; test_in = tst;
        exec({4'h1, c}, 8'hE7);
        check(req, {4'h0, pc}, take ? 16'h00E7 : 16'h0052);
        acc_zero = 1'b0; carry = 1'b0; test_in = 1'b1;
    endtask

    task automatic t_cond();
        do_reset();
        cond_case("R9 empty mask never", 4'h0, 1'b1, 1'b1, 1'b0, 1'b0);
        cond_case("R9 acc zero taken", 4'h4, 1'b1, 1'b0, 1'b1, 1'b1);
        cond_case("R9 acc zero not", 4'h4, 1'b0, 1'b1, 1'b0, 1'b0);
        cond_case("R9 carry taken", 4'h2, 1'b0, 1'b1, 1'b1, 1'b1);
        cond_case("R9 carry not", 4'h2, 1'b1, 1'b0, 1'b0, 1'b0);
        cond_case("R9 test low taken", 4'h1, 1'b0, 1'b0, 1'b0, 1'b1);
        cond_case("R9 test high not", 4'h1, 1'b1, 1'b1, 1'b1, 1'b0);
        cond_case("R9 terms ORed", 4'h6, 1'b0, 1'b1, 1'b1, 1'b1);
        cond_case("R10 invert empty always", 4'h8, 1'b0, 1'b0, 1'b1, 1'b1);
        cond_case("R10 invert blocks", 4'hC, 1'b1, 1'b0, 1'b1, 1'b0);
        cond_case("R10 invert after OR", 4'hE, 1'b0, 1'b1, 1'b1, 1'b0);
        go_to(12'h0FE);
        acc_zero = 1'b1;
        exec(8'h14, 8'h34);
        acc_zero = 1'b0;
        check("R11 page crossing", {4'h0, pc}, 16'h0134);
        go_to(12'h3FD);
        exec(8'h18, 8'h20);
        check("R11 same page", {4'h0, pc}, 16'h0320);
    endtask

    task automatic t_indirect();
        do_reset();
        go_to(12'h2FF);
        pair_data = 8'h5A;
        exec(8'h31, 8'h00);
        check("R12 indirect page crossing", {4'h0, pc}, 16'h035A);
        go_to(12'h7C0);
        pair_data = 8'h03;
        exec(8'h35, 8'h00);
        check("R12 indirect same page", {4'h0, pc}, 16'h0703);
        exec(8'h32, 8'h00);
        check("R12 even pair advances", {4'h0, pc}, 16'h0704);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_sequential();
        t_fetch2();
        t_long();
        t_nest();
        t_overflow();
        t_cond();
        t_indirect();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule